// File: doc/BRIEF.md
# NEC Infrared Remote Receiver

This block is a memory-mapped receiver for NEC-format infrared remote frames. It samples an already demodulated infrared input once per sample tick and passes it through a deglitch filter whose strength software selects. A timing decoder then measures the mark and space lengths of the filtered signal. A full data frame leaves its 32-bit payload in a code register. A repeat frame is reported through a flag in a separate count register, and the code register is not touched.

Each completed frame, data or repeat, sets an interrupt status bit. The interrupt output is that status gated by an enable bit, and software writes 1 to the status register to clear it. A watchdog counter, reloaded on every accepted edge, abandons a frame whose next edge never arrives. Software does the checking of the inverted bytes and the key mapping.

Top module: `nec_ir_rx`

## Requirements
- R1: After reset, the registers read as follows: enable (0x04), interrupt enable (0x10), status (0x14), code (0x30) and count (0x34) are zero, and control (0x08) reads 0x00021C00, which is a watchdog start of 0x21C in bits 18:8 and deglitch level 0 in bits 21:20. A read of any other address returns zero.
- R2: The decoder runs only while bit 0 of the enable register (0x04) is 1. While that bit is 0, no frame completes, the status bit stays 0 and the code register keeps its value.
- R3: The deglitch level L in control bits 21:20 requires 2^L consecutive sample ticks at a new input level before an edge is accepted. At level 0 a change of one tick is accepted. At level 1 a one-tick pulse is discarded.
- R4: The watchdog start value in control bits 18:8 is reloaded on every accepted edge and counts down once per tick while a frame is in progress. When it runs out, the frame is abandoned and no status is raised.
- R5: ir_in = 1 is a mark. A data frame is a leader mark of 160 ticks, a leader space of 80 ticks, 32 bits, and a closing mark of 10 ticks. The bits arrive least significant first, and each bit is a 10-tick mark followed by its space. The code register (0x30) holds bits [7:0] = address, [15:8] = inverted address, [23:16] = command, [31:24] = inverted command.
- R6: A repeat frame is a leader mark, a space of 40 ticks and a 10-tick mark. It sets bit 16 of the count register (0x34), sets bits 7:0 of that register to 0, and leaves the code register unchanged.
- R7: Each completed frame sets status bit 0 (0x14). Writing 1 to bit 0 of 0x14 clears it. irq equals status bit 0 AND interrupt enable bit 0 (0x10).
- R8: A pulse is accepted when its length in ticks lies within nominal ± nominal/5 (integer division). A 10-tick space decodes as 0 and a 30-tick space decodes as 1. A 12-tick bit mark is accepted and a 13-tick bit mark is not.
- R9: A completed data frame clears bit 16 of the count register and sets bits 7:0 of that register to 32.
- R10: An out-of-window pulse, a watchdog expiry or a disable returns the decoder to idle. The code and count registers are left unchanged and no status is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ir_in | input | 1 | Demodulated infrared input, 1 = mark |
| irq | output | 1 | Level interrupt |

## Verification
Data frames with different address and command bytes check the byte packing and the least-significant-first bit order. A repeat frame placed between two data frames shows that the repeat flag is set and then cleared while the code register holds its value. Bit marks of 12 and 13 ticks probe the edge of the tolerance window. The same one-tick glitch is sent at deglitch level 1 and at level 0: the frame should survive it at level 1 and be lost at level 0. The same frame is also sent with a short and with the default watchdog start, so that a watchdog abort is told apart from a timing failure.

// File: rtl/nec_ir_pkg.sv
package nec_ir_pkg;

  localparam int CODE_BITS = 32;
  localparam int CNT_W     = 11;
  localparam int LVL_W     = 2;

  localparam int OFS_ENABLE = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_INTEN  = 'h10;
  localparam int OFS_STATUS = 'h14;
  localparam int OFS_CODE   = 'h30;
  localparam int OFS_COUNT  = 'h34;

  localparam logic [31:0] CTRL_MASK = 32'h0037_FF00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_M,
    ST_LEAD_S,
    ST_BIT_M,
    ST_BIT_S,
    ST_STOP_M,
    ST_RPT_M
  } fr_state_e;

  // True when a pulse of len ticks lies within nominal +/- nominal/5
  function automatic logic in_window(input int unsigned len, input int unsigned nom);
    int unsigned lo;
    int unsigned hi;
    lo = nom - nom / 5;
    hi = nom + nom / 5;
    return (len >= lo) && (len <= hi);
  endfunction

  // Consecutive stable samples needed before an edge is accepted
  function automatic int unsigned degl_need(input logic [LVL_W-1:0] lvl);
    return 32'd1 << lvl;
  endfunction

endpackage

// File: rtl/nec_ir_tick.sv
module nec_ir_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/nec_ir_deglitch.sv
module nec_ir_deglitch
  import nec_ir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             raw_in,
  input  logic [LVL_W-1:0] level,
  output logic             accept,
  output logic             new_level
);
  logic s1, s2, filt;
  logic [3:0] run;
  logic differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw_in;
      s2 <= s1;
    end
  end

  assign differs   = (s2 != filt);
  assign accept    = tick && differs && ((32'(run) + 32'd1) >= degl_need(level));
  assign new_level = s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      run  <= '0;
    end else if (tick) begin
      if (accept) begin
        filt <= s2;
        run  <= '0;
      end else if (differs) begin
        run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/nec_ir_framer.sv
module nec_ir_framer
  import nec_ir_pkg::*;
#(
  parameter int LEAD_MARK  = 160,
  parameter int LEAD_SPACE = 80,
  parameter int RPT_SPACE  = 40,
  parameter int BIT_MARK   = 10,
  parameter int ZERO_SPACE = 10,
  parameter int ONE_SPACE  = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 accept,
  input  logic                 new_level,
  input  logic [CNT_W-1:0]     wd_start,
  output logic                 frame_ok,
  output logic                 rpt_ok,
  output logic                 abort_evt,
  output logic [CODE_BITS-1:0] code,
  output logic [7:0]           nbits
);
  localparam int NB_W = $clog2(CODE_BITS) + 1;
  localparam logic [NB_W-1:0] LAST_BIT = NB_W'(CODE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fr_state_e st, st_n;
  logic [CNT_W-1:0] cnt, wd;
  logic [NB_W-1:0]  nbit;
  logic [CODE_BITS-1:0] shreg;
  int unsigned len;
  logic ok_n, rpt_n, bit_take, bit_v, bad_pulse, wd_expire;

  assign len = 32'(cnt) + 32'd1;

  always_comb begin
    st_n     = st;
    ok_n     = 1'b0;
    rpt_n    = 1'b0;
    bit_take = 1'b0;
    bit_v    = 1'b0;
    if (accept) begin
      case (st)
        ST_IDLE:   if (new_level) st_n = ST_LEAD_M;
        ST_LEAD_M: st_n = (!new_level && in_window(len, LEAD_MARK)) ? ST_LEAD_S : ST_IDLE;
        ST_LEAD_S: begin
          if (new_level && in_window(len, LEAD_SPACE)) st_n = ST_BIT_M;
          else if (new_level && in_window(len, RPT_SPACE)) st_n = ST_RPT_M;
          else st_n = ST_IDLE;
        end
        ST_BIT_M:  st_n = (!new_level && in_window(len, BIT_MARK)) ? ST_BIT_S : ST_IDLE;
        ST_BIT_S: begin
          if (new_level && (in_window(len, ZERO_SPACE) || in_window(len, ONE_SPACE))) begin
            bit_take = 1'b1;
            bit_v    = in_window(len, ONE_SPACE);
            st_n     = (nbit == LAST_BIT) ? ST_STOP_M : ST_BIT_M;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_STOP_M: begin
          ok_n = !new_level && in_window(len, BIT_MARK);
          st_n = ST_IDLE;
        end
        ST_RPT_M: begin
          rpt_n = !new_level && in_window(len, BIT_MARK);
          st_n  = ST_IDLE;
        end
        default:   st_n = ST_IDLE;
      endcase
    end
  end

  assign bad_pulse = accept && (st != ST_IDLE) && (st_n == ST_IDLE) && !ok_n && !rpt_n;
  assign wd_expire = tick && !accept && (st != ST_IDLE) && (wd == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      wd        <= '0;
      nbit      <= '0;
      shreg     <= '0;
      frame_ok  <= 1'b0;
      rpt_ok    <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      rpt_ok    <= 1'b0;
      abort_evt <= 1'b0;
      if (!en) begin
        st        <= ST_IDLE;
        abort_evt <= (st != ST_IDLE);
      end else if (tick) begin
        if (accept) begin
          cnt       <= '0;
          wd        <= wd_start;
          st        <= st_n;
          frame_ok  <= ok_n;
          rpt_ok    <= rpt_n;
          abort_evt <= bad_pulse;
          if (st == ST_IDLE) nbit <= '0;
          if (bit_take) begin
            shreg <= {bit_v, shreg[CODE_BITS-1:1]};
            nbit  <= nbit + 1'b1;
          end
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (wd_expire) begin
            st        <= ST_IDLE;
            abort_evt <= 1'b1;
          end else if (st != ST_IDLE) begin
            wd <= wd - 1'b1;
          end
        end
      end
    end
  end

  assign code  = shreg;
  assign nbits = 8'(nbit);
endmodule

// File: rtl/nec_ir_regs.sv
module nec_ir_regs
  import nec_ir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [CNT_W-1:0] WD_DEFAULT = 11'h21C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 frame_ok,
  input  logic                 rpt_ok,
  input  logic [CODE_BITS-1:0] code_in,
  input  logic [7:0]           nbits_in,
  output logic                 en,
  output logic                 inten,
  output logic                 status,
  output logic [LVL_W-1:0]     degl_lvl,
  output logic [CNT_W-1:0]     wd_start,
  output logic [CODE_BITS-1:0] code_q,
  output logic                 rpt_flag,
  output logic                 irq
);
  localparam logic [31:0] CTRL_RESET = 32'(WD_DEFAULT) << 8;

  logic [31:0] ctrl_q;
  logic [7:0]  nbits_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      inten    <= 1'b0;
      status   <= 1'b0;
      ctrl_q   <= CTRL_RESET;
      code_q   <= '0;
      rpt_flag <= 1'b0;
      nbits_q  <= '0;
    end else begin
      if (bus_we && hit(bus_addr, OFS_ENABLE)) en <= bus_wdata[0];
      if (bus_we && hit(bus_addr, OFS_CTRL))   ctrl_q <= bus_wdata & CTRL_MASK;
      if (bus_we && hit(bus_addr, OFS_INTEN))  inten <= bus_wdata[0];
      if (frame_ok || rpt_ok) status <= 1'b1;
      else if (bus_we && hit(bus_addr, OFS_STATUS) && bus_wdata[0]) status <= 1'b0;
      if (frame_ok) begin
        code_q   <= code_in;
        rpt_flag <= 1'b0;
        nbits_q  <= nbits_in;
      end else if (rpt_ok) begin
        rpt_flag <= 1'b1;
        nbits_q  <= 8'd0;
      end
    end
  end

  assign degl_lvl = ctrl_q[21:20];
  assign wd_start = ctrl_q[18:8];
  assign irq      = status & inten;

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_ENABLE))      bus_rdata = {31'd0, en};
    else if (hit(bus_addr, OFS_CTRL))   bus_rdata = ctrl_q;
    else if (hit(bus_addr, OFS_INTEN))  bus_rdata = {31'd0, inten};
    else if (hit(bus_addr, OFS_STATUS)) bus_rdata = {31'd0, status};
    else if (hit(bus_addr, OFS_CODE))   bus_rdata = code_q;
    else if (hit(bus_addr, OFS_COUNT))  bus_rdata = {15'd0, rpt_flag, 8'd0, nbits_q};
  end
endmodule

// File: rtl/nec_ir_rx.sv
module nec_ir_rx
  import nec_ir_pkg::*;
#(
  parameter int TICK_DIV   = 1125,
  parameter int LEAD_MARK  = 160,
  parameter int LEAD_SPACE = 80,
  parameter int RPT_SPACE  = 40,
  parameter int BIT_MARK   = 10,
  parameter int ZERO_SPACE = 10,
  parameter int ONE_SPACE  = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ir_in,
  output logic        irq
);
  logic tick, accept, new_level;
  logic frame_ok, rpt_ok, abort_evt;
  logic en, inten, status, rpt_flag;
  logic [LVL_W-1:0] degl_lvl;
  logic [CNT_W-1:0] wd_start;
  logic [CODE_BITS-1:0] fr_code, code_q;
  logic [7:0] fr_nbits;

  nec_ir_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  nec_ir_deglitch u_degl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_in(ir_in),
    .level(degl_lvl), .accept(accept), .new_level(new_level)
  );

  nec_ir_framer #(
    .LEAD_MARK(LEAD_MARK), .LEAD_SPACE(LEAD_SPACE), .RPT_SPACE(RPT_SPACE),
    .BIT_MARK(BIT_MARK), .ZERO_SPACE(ZERO_SPACE), .ONE_SPACE(ONE_SPACE)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .accept(accept),
    .new_level(new_level), .wd_start(wd_start), .frame_ok(frame_ok),
    .rpt_ok(rpt_ok), .abort_evt(abort_evt), .code(fr_code), .nbits(fr_nbits)
  );

  nec_ir_regs #(.ADDR_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_ok(frame_ok),
    .rpt_ok(rpt_ok), .code_in(fr_code), .nbits_in(fr_nbits), .en(en),
    .inten(inten), .status(status), .degl_lvl(degl_lvl), .wd_start(wd_start),
    .code_q(code_q), .rpt_flag(rpt_flag), .irq(irq)
  );
endmodule

// File: rtl/nec_ir_rx_chk.sv
module nec_ir_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic        clr_bit,
  input logic        irq,
  input logic        frame_ok,
  input logic        rpt_ok,
  input logic        abort_evt,
  input logic        en,
  input logic        inten,
  input logic        status,
  input logic [31:0] code_q,
  input logic        rpt_flag
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!frame_ok && !rpt_ok)); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h14 && clr_bit && !frame_ok && !rpt_ok) |=> !irq); // R7
  AST_EVT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_ok || rpt_ok) && inten && !bus_we) |=> irq); // R7
  AST_STATUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(frame_ok || rpt_ok)); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(code_q)); // R10
  AST_RPT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ok |=> rpt_flag); // R6
  AST_RPT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !rpt_flag); // R9
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, rpt_ok, abort_evt})); // R10
endmodule

bind nec_ir_rx nec_ir_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .clr_bit(bus_wdata[0]), .irq(irq), .frame_ok(frame_ok), .rpt_ok(rpt_ok),
  .abort_evt(abort_evt), .en(en), .inten(inten), .status(status),
  .code_q(code_q), .rpt_flag(rpt_flag)
);

// File: tb/nec_ir_rx_test.sv
module nec_ir_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ir_in = 1'b0;
  logic irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nec_ir_rx #(.TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ir_in(ir_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic lvl(input logic v, input int n);
    ir_in = v;
    repeat (n * TD) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] a, input logic [7:0] c);
    return {~c, c, ~a, a};
  endfunction

  task automatic send_frame(input logic [31:0] code, input int markw, input int gbit);
    @(negedge clk);
    lvl(1, 160); lvl(0, 80);
    for (int i = 0; i < 32; i++) begin
      int s;
      s = code[i] ? 30 : 10;
      lvl(1, markw);
      if (i == gbit) begin
        lvl(0, s / 2 - 1); lvl(1, 1); lvl(0, s - s / 2);
      end else begin
        lvl(0, s);
      end
    end
    lvl(1, markw); lvl(0, 40);
  endtask

  task automatic send_repeat();
    @(negedge clk);
    lvl(1, 160); lvl(0, 40); lvl(1, 10); lvl(0, 40);
  endtask

  task automatic clear_irq();
    wr(8'h14, 32'h1);
  endtask

  task automatic t_reset();
    rd(8'h04, rv); chk("R1 enable reset", rv, 32'h0);
    rd(8'h08, rv); chk("R1 ctrl reset", rv, 32'h0002_1C00);
    rd(8'h10, rv); chk("R1 inten reset", rv, 32'h0);
    rd(8'h14, rv); chk("R1 status reset", rv, 32'h0);
    rd(8'h30, rv); chk("R1 code reset", rv, 32'h0);
    rd(8'h34, rv); chk("R1 count reset", rv, 32'h0);
    rd(8'h00, rv); chk("R1 undefined 0x00", rv, 32'h0);
    rd(8'h3C, rv); chk("R1 undefined 0x3C", rv, 32'h0);
    chk("R1 irq reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_disabled();
    wr(8'h10, 32'h1);
    send_frame(mk(8'h11, 8'h22), 10, -1);
    rd(8'h14, rv); chk("R2 no status while disabled", rv, 32'h0);
    rd(8'h30, rv); chk("R2 code kept while disabled", rv, 32'h0);
    chk("R2 irq low while disabled", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_frame(input logic [31:0] exp);
    send_frame(exp, 10, -1);
    rd(8'h30, rv); chk("R5 code packing", rv, exp);
    rd(8'h34, rv); chk("R9 count after data frame", rv, 32'd32);
    rd(8'h14, rv); chk("R7 status set", rv, 32'h1);
    chk("R7 irq raised", {31'd0, irq}, 32'h1);
    clear_irq();
    rd(8'h14, rv); chk("R7 status cleared", rv, 32'h0);
    chk("R7 irq dropped", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_repeat(input logic [31:0] prev);
    send_repeat();
    rd(8'h34, rv); chk("R6 repeat flag and count", rv, 32'h0001_0000);
    rd(8'h30, rv); chk("R6 code unchanged on repeat", rv, prev);
    chk("R6 irq on repeat", {31'd0, irq}, 32'h1);
    clear_irq();
  endtask

  task automatic t_inten(input logic [31:0] exp);
    wr(8'h10, 32'h0);
    send_frame(exp, 10, -1);
    chk("R7 irq masked", {31'd0, irq}, 32'h0);
    rd(8'h14, rv); chk("R7 status set while masked", rv, 32'h1);
    wr(8'h10, 32'h1);
    chk("R7 irq after unmask", {31'd0, irq}, 32'h1);
    clear_irq();
  endtask

  task automatic t_window(input logic [31:0] good, input logic [31:0] bad);
    send_frame(good, 12, -1);
    rd(8'h30, rv); chk("R8 mark of 12 accepted", rv, good);
    clear_irq();
    send_frame(bad, 13, -1);
    rd(8'h14, rv); chk("R10 mark of 13 no status", rv, 32'h0);
    rd(8'h30, rv); chk("R10 mark of 13 code kept", rv, good);
    rd(8'h34, rv); chk("R10 mark of 13 count kept", rv, 32'd32);
  endtask

  task automatic t_deglitch(input logic [31:0] a, input logic [31:0] b);
    wr(8'h08, (32'd1 << 20) | (32'h21C << 8));
    rd(8'h08, rv); chk("R3 ctrl readback level 1", rv, 32'h0012_1C00);
    send_frame(a, 10, 5);
    rd(8'h30, rv); chk("R3 glitch filtered at level 1", rv, a);
    clear_irq();
    wr(8'h08, 32'h21C << 8);
    send_frame(b, 10, 5);
    rd(8'h14, rv); chk("R3 glitch breaks frame at level 0", rv, 32'h0);
    rd(8'h30, rv); chk("R3 code kept after glitch", rv, a);
  endtask

  task automatic t_watchdog(input logic [31:0] c);
    wr(8'h08, 32'd50 << 8);
    rd(8'h08, rv); chk("R4 ctrl readback watchdog", rv, 32'h0000_3200);
    send_frame(c, 10, -1);
    rd(8'h14, rv); chk("R4 short watchdog aborts", rv, 32'h0);
    wr(8'h08, 32'h21C << 8);
    send_frame(c, 10, -1);
    rd(8'h30, rv); chk("R4 default watchdog decodes", rv, c);
    clear_irq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    wr(8'h04, 32'h1);
    rd(8'h04, rv); chk("R2 enable readback", rv, 32'h1);
    t_frame(mk(8'h0F, 8'h4A));
    t_repeat(mk(8'h0F, 8'h4A));
    t_frame(mk(8'hA5, 8'h3C));
    t_inten(mk(8'h5A, 8'h81));
    t_window(mk(8'h33, 8'hC7), mk(8'h44, 8'h18));
    t_deglitch(mk(8'h96, 8'h2B), mk(8'h01, 8'hFE));
    t_watchdog(mk(8'h7E, 8'h55));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule